// File: doc/BRIEF.md
# DMA External Request Handshake Unit

This block sits between external peripherals and the DMA channel arbiter. Each channel watches an active-low request pin and tells the arbiter when a request is pending. It tells the device when the arbiter has taken the request, and it marks each data transfer with an acknowledge strobe. The request pin is brought into the clock domain through a two-stage synchronizer. It is then read either as a level, where the request lasts while the pin stays low, or as an edge, where one falling transition asks for exactly one service.

When the arbiter grants a pending request, the unit gives the device a one-cycle request-accepted strobe. It then drives the acknowledge during the bus phase chosen by configuration. In dual address mode this is the read phase or the write phase. In single address mode it is every phase of the transfer. Both outputs have their own polarity bit. Only the lowest `CFG_CH` channels obey their configuration bits. Every higher channel runs as if all four of its bits were zero.

Top module: `dma_xreq_hs`

## Requirements
- R1: While reset is applied, and after it, no request is pending. `acc_out` rests at its inactive level and `ack_out` rests at its inactive level, as long as the bus phase inputs are idle.
- R2: When `cfg_edge_det`=0 (level detection), a channel that is not busy raises `req_pend` after the third rising edge at which `xreq_n` is sampled low. `req_pend` falls again after the third rising edge at which `xreq_n` is sampled high.
- R3: In level detection, an accepted grant clears `req_pend` at that edge. The channel is then busy, and `req_pend` stays low until the edge that samples `xfer_done`=1. From that edge on, `req_pend` again follows the synchronized pin.
- R4: When `cfg_edge_det`=1 (edge detection), a falling transition of `xreq_n` sets `req_pend` three edges after the first low sample. `req_pend` stays set after the pin returns high and is cleared only by an accepted grant. A new falling edge detected at that same edge keeps it set.
- R5: A grant is accepted when `grant` and `req_pend` are both 1 at a rising edge. `acc_out` is active for exactly the one cycle that follows. A grant while nothing is pending is ignored.
- R6: With `cfg_acc_low`=0, `acc_out` is active-high (idle 0). With `cfg_acc_low`=1, it is active-low (idle 1).
- R7: When `single_addr`=0 (dual address mode), `ack_out` is active in the same cycle as `cyc_rd` if `cfg_ack_on_wr`=0, and in the same cycle as `cyc_wr` if `cfg_ack_on_wr`=1. It is inactive otherwise.
- R8: When `single_addr`=1, `ack_out` is active whenever `cyc_rd` or `cyc_wr` is 1, whatever the value of `cfg_ack_on_wr`.
- R9: With `cfg_ack_low`=0, `ack_out` is active-high. With `cfg_ack_low`=1, it is active-low.
- R10: On channels with index CFG_CH (default 2) or above, all four configuration bits are ignored. Such a channel behaves as level-detect, active-high accept, read-phase acknowledge and active-high acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_edge_det | input | NUM_CH | 1 = falling-edge detection, 0 = low-level detection |
| cfg_acc_low | input | NUM_CH | 1 = request-accepted output is active-low |
| cfg_ack_on_wr | input | NUM_CH | Dual address mode: 1 = acknowledge in write phase, 0 = read phase |
| cfg_ack_low | input | NUM_CH | 1 = acknowledge output is active-low |
| xreq_n | input | NUM_CH | Active-low request pins from devices |
| grant | input | NUM_CH | Arbiter grant per channel |
| xfer_done | input | NUM_CH | Transfer engine: current transfer of the channel has finished |
| cyc_rd | input | NUM_CH | Transfer engine: channel is in its data read phase |
| cyc_wr | input | NUM_CH | Transfer engine: channel is in its data write phase |
| single_addr | input | NUM_CH | 1 = single address mode, 0 = dual address mode |
| req_pend | output | NUM_CH | Pending request to the arbiter |
| acc_out | output | NUM_CH | Request-accepted strobe to the device |
| ack_out | output | NUM_CH | Per-transfer acknowledge to the device |

## Verification
Some rules are checked on every cycle. An accepted strobe must come directly after an accepted grant. A grant that is accepted must produce that strobe. A pending edge request must be held until it is granted, and a level request must drop at its grant. The acknowledge must follow the single-address rule and stay quiet outside the selected dual-address phase. Only the bench scenarios can show the rest: the three-edge synchronizer latency, the level request returning after the transfer ends, the effect of each polarity bit, and the upper channels ignoring all of their configuration.

// File: rtl/dma_hs_pkg.sv
// Shared types for the DMA external request handshake unit.
// Assumes: per-channel configuration is four independent bits.
package dma_hs_pkg;

    typedef struct packed {
        logic edge_det;   // 1: falling-edge detect, 0: low-level detect
        logic acc_low;    // request-accepted output active-low
        logic ack_on_wr;  // dual address: acknowledge in write phase
        logic ack_low;    // acknowledge output active-low
    } ch_cfg_t;

    localparam ch_cfg_t CFG_DEFAULT = '{edge_det: 1'b0, acc_low: 1'b0,
                                        ack_on_wr: 1'b0, ack_low: 1'b0};

endpackage

// File: rtl/dma_hs_sync.sv
// Multi-stage synchronizer for one asynchronous-origin bit.
// Assumes: the input is a slow device pin; STAGES >= 2; resets to RST_VAL.
module dma_hs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the pin value through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/dma_hs_reqdet.sv
// Request detector for one channel: turns the synchronized active-low pin
// into a pending flag, level or sticky-edge, and tracks the busy window
// from accepted grant to transfer completion.
// Assumes: grant and done are single-cycle qualified by the transfer engine.
module dma_hs_reqdet (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_mode,
    input  logic sync_n,
    input  logic grant,
    input  logic done,
    output logic pend,
    output logic accept
);
    logic sync_prev;
    logic busy;
    logic fall;
    logic busy_nxt;

    // Grant is honoured only when something is pending.
    assign accept   = grant & pend;
    // Falling transition between consecutive synchronized samples.
    assign fall     = sync_prev & ~sync_n;
    // A new acceptance wins over a completion in the same cycle.
    assign busy_nxt = accept | (busy & ~done);

    // Hold previous sample, busy window and pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_prev <= 1'b1;
            busy      <= 1'b0;
            pend      <= 1'b0;
        end else begin
            sync_prev <= sync_n;
            busy      <= busy_nxt;
            if (edge_mode) begin
                pend <= fall | (pend & ~accept);
            end else begin
                pend <= ~sync_n & ~busy_nxt;
            end
        end
    end
endmodule

// File: rtl/dma_hs_outdrv.sv
// Output driver for one channel: one-cycle accepted strobe after a grant,
// acknowledge steered to the selected bus phase, polarity on both outputs.
// Assumes: cyc_rd / cyc_wr only assert while this channel owns the bus.
module dma_hs_outdrv (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic acc_low,
    input  logic ack_on_wr,
    input  logic ack_low,
    input  logic single,
    input  logic cyc_rd,
    input  logic cyc_wr,
    output logic acc_out,
    output logic ack_out
);
    logic acc_q;
    logic ack_act;

    // Register the acceptance into a single-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= 1'b0;
        end else begin
            acc_q <= accept;
        end
    end

    // Select the phase in which the acknowledge is active.
    always_comb begin
        if (single) begin
            ack_act = cyc_rd | cyc_wr;
        end else if (ack_on_wr) begin
            ack_act = cyc_wr;
        end else begin
            ack_act = cyc_rd;
        end
    end

    assign acc_out = acc_q ^ acc_low;
    assign ack_out = ack_act ^ ack_low;
endmodule

// File: rtl/dma_xreq_hs.sv
// DMA external request handshake unit for NUM_CH channels. Channels below
// CFG_CH honour their configuration bits; the rest run on defaults.
// Assumes: all inputs are synchronous except xreq_n.
module dma_xreq_hs
    import dma_hs_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int CFG_CH      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] cfg_edge_det,
    input  logic [NUM_CH-1:0] cfg_acc_low,
    input  logic [NUM_CH-1:0] cfg_ack_on_wr,
    input  logic [NUM_CH-1:0] cfg_ack_low,
    input  logic [NUM_CH-1:0] xreq_n,
    input  logic [NUM_CH-1:0] grant,
    input  logic [NUM_CH-1:0] xfer_done,
    input  logic [NUM_CH-1:0] cyc_rd,
    input  logic [NUM_CH-1:0] cyc_wr,
    input  logic [NUM_CH-1:0] single_addr,
    output logic [NUM_CH-1:0] req_pend,
    output logic [NUM_CH-1:0] acc_out,
    output logic [NUM_CH-1:0] ack_out
);
    localparam int NCFG = (CFG_CH < NUM_CH) ? CFG_CH : NUM_CH;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ch_cfg_t eff;
        logic    sync_n;
        logic    accept;

        if (g < NCFG) begin : g_cfg
            // Configurable channel: take the programmed bits.
            assign eff = '{edge_det: cfg_edge_det[g], acc_low: cfg_acc_low[g],
                           ack_on_wr: cfg_ack_on_wr[g], ack_low: cfg_ack_low[g]};
        end else begin : g_fixed
            logic unused_cfg_bits;
            // Fixed channel: programmed bits have no effect.
            assign unused_cfg_bits = ^{cfg_edge_det[g], cfg_acc_low[g],
                                       cfg_ack_on_wr[g], cfg_ack_low[g]};
            assign eff = CFG_DEFAULT;
        end

        dma_hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (xreq_n[g]),
            .dout  (sync_n)
        );

        dma_hs_reqdet u_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .edge_mode (eff.edge_det),
            .sync_n    (sync_n),
            .grant     (grant[g]),
            .done      (xfer_done[g]),
            .pend      (req_pend[g]),
            .accept    (accept)
        );

        dma_hs_outdrv u_out (
            .clk       (clk),
            .rst_n     (rst_n),
            .accept    (accept),
            .acc_low   (eff.acc_low),
            .ack_on_wr (eff.ack_on_wr),
            .ack_low   (eff.ack_low),
            .single    (single_addr[g]),
            .cyc_rd    (cyc_rd[g]),
            .cyc_wr    (cyc_wr[g]),
            .acc_out   (acc_out[g]),
            .ack_out   (ack_out[g])
        );
    end
endmodule

// File: rtl/dma_xreq_hs_chk.sv
// Property checker for dma_xreq_hs, attached with bind below.
module dma_xreq_hs_chk #(
    parameter int NUM_CH      = 4,
    parameter int CFG_CH      = 2,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] cfg_edge_det,
    input logic [NUM_CH-1:0] cfg_acc_low,
    input logic [NUM_CH-1:0] cfg_ack_on_wr,
    input logic [NUM_CH-1:0] cfg_ack_low,
    input logic [NUM_CH-1:0] xreq_n,
    input logic [NUM_CH-1:0] grant,
    input logic [NUM_CH-1:0] xfer_done,
    input logic [NUM_CH-1:0] cyc_rd,
    input logic [NUM_CH-1:0] cyc_wr,
    input logic [NUM_CH-1:0] single_addr,
    input logic [NUM_CH-1:0] req_pend,
    input logic [NUM_CH-1:0] acc_out,
    input logic [NUM_CH-1:0] ack_out
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_c
        logic e_edge, e_ap, e_wr, e_kp;
        assign e_edge = (g < CFG_CH) ? cfg_edge_det[g]  : 1'b0;
        assign e_ap   = (g < CFG_CH) ? cfg_acc_low[g]   : 1'b0;
        assign e_wr   = (g < CFG_CH) ? cfg_ack_on_wr[g] : 1'b0;
        assign e_kp   = (g < CFG_CH) ? cfg_ack_low[g]   : 1'b0;

        // R1
        rst_idle_chk: assert property (@(posedge clk)
            !rst_n |=> !req_pend[g] && (acc_out[g] == e_ap));

        // R5
        acc_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_out[g] != e_ap) |-> $past(grant[g] && req_pend[g]));

        // R5
        grant_to_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[g] && req_pend[g]) |=> (acc_out[g] != e_ap));

        // R4
        edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (e_edge && req_pend[g] && !grant[g]) |=> req_pend[g]);

        // R3
        lvl_grant_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!e_edge && grant[g] && req_pend[g]) |=> !req_pend[g]);

        // R8
        single_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (single_addr[g] && (cyc_rd[g] || cyc_wr[g])) |-> (ack_out[g] != e_kp));

        // R7
        dual_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!single_addr[g] && (e_wr ? !cyc_wr[g] : !cyc_rd[g])) |-> (ack_out[g] == e_kp));
    end
endmodule

bind dma_xreq_hs dma_xreq_hs_chk #(
    .NUM_CH(NUM_CH), .CFG_CH(CFG_CH), .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/dma_xreq_hs_tb.sv
// Bench for dma_xreq_hs: behavioural reference compared every cycle plus
// directed checks per requirement.
module dma_xreq_hs_tb;
    localparam int NCH = 4;
    localparam int NCFG = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] cfg_edge_det = '0, cfg_acc_low = '0, cfg_ack_on_wr = '0, cfg_ack_low = '0;
    logic [NCH-1:0] xreq_n = '1, grant = '0, xfer_done = '0;
    logic [NCH-1:0] cyc_rd = '0, cyc_wr = '0, single_addr = '0;
    logic [NCH-1:0] req_pend, acc_out, ack_out;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    dma_xreq_hs #(.NUM_CH(NCH), .CFG_CH(NCFG)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_edge_det(cfg_edge_det), .cfg_acc_low(cfg_acc_low),
        .cfg_ack_on_wr(cfg_ack_on_wr), .cfg_ack_low(cfg_ack_low),
        .xreq_n(xreq_n), .grant(grant), .xfer_done(xfer_done),
        .cyc_rd(cyc_rd), .cyc_wr(cyc_wr), .single_addr(single_addr),
        .req_pend(req_pend), .acc_out(acc_out), .ack_out(ack_out)
    );

    // Reference model: sample history of the pin, pending, busy, strobe.
    int hist [NCH][$];
    bit m_pend [NCH];
    bit m_busy [NCH];
    bit m_acc  [NCH];

    function automatic bit eff(input logic [NCH-1:0] v, input int i);
        return (i < NCFG) ? v[i] : 1'b0;
    endfunction

    always @(posedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (!rst_n) begin
                hist[i] = '{1, 1, 1};
                m_pend[i] = 0; m_busy[i] = 0; m_acc[i] = 0;
            end else begin
                bit take, nbusy;
                int last1, last2;
                last1 = hist[i][1];  // synchronized value now
                last2 = hist[i][2];  // synchronized value one cycle earlier
                take  = grant[i] && m_pend[i];
                nbusy = take || (m_busy[i] && !xfer_done[i]);
                if (eff(cfg_edge_det, i))
                    m_pend[i] = (last2 == 1 && last1 == 0) || (m_pend[i] && !take);
                else
                    m_pend[i] = (last1 == 0) && !nbusy;
                m_busy[i] = nbusy;
                m_acc[i]  = take;
                hist[i].push_front(int'(xreq_n[i]));
                void'(hist[i].pop_back());
            end
        end
    end

    function automatic bit m_ack(input int i);
        bit a;
        if (single_addr[i]) a = cyc_rd[i] | cyc_wr[i];
        else if (eff(cfg_ack_on_wr, i)) a = cyc_wr[i];
        else a = cyc_rd[i];
        return a ^ eff(cfg_ack_low, i);
    endfunction

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            for (int i = 0; i < NCH; i++) begin
                bit ep, ea, ek;
                ep = m_pend[i];
                ea = m_acc[i] ^ eff(cfg_acc_low, i);
                ek = m_ack(i);
                n_chk++;
                if (req_pend[i] !== ep || acc_out[i] !== ea || ack_out[i] !== ek) begin
                    n_fail++;
                    $display("FAIL %s model ch%0d: pend/acc/ack actual %b%b%b expected %b%b%b",
                             cur_req, i, req_pend[i], acc_out[i], ack_out[i], ep, ea, ek);
                end
            end
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #5;
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        cfg_edge_det[1] = 1'b1;
        step(3);
        // R1: outputs idle during reset
        check("R1", req_pend[0], 1'b0);
        check("R1", acc_out[0], 1'b0);
        check("R1", ack_out[1], 1'b0);
        rst_n = 1'b1;
        step(4);
        check("R1", |req_pend, 1'b0);

        // R2: level detect latency
        cur_req = "R2";
        xreq_n[0] = 1'b0;
        step(2);
        check("R2", req_pend[0], 1'b0);
        step(1);
        check("R2", req_pend[0], 1'b1);

        // R3/R5: grant clears, strobe for one cycle, held through busy window
        cur_req = "R3";
        grant[0] = 1'b1;
        step(1);
        grant[0] = 1'b0;
        check("R3", req_pend[0], 1'b0);
        check("R5", acc_out[0], 1'b1);
        step(1);
        check("R5", acc_out[0], 1'b0);
        step(4);
        check("R3", req_pend[0], 1'b0);
        xfer_done[0] = 1'b1;
        step(1);
        xfer_done[0] = 1'b0;
        check("R3", req_pend[0], 1'b1);
        // pin released: withdrawn after three high samples
        cur_req = "R2";
        xreq_n[0] = 1'b1;
        step(2);
        check("R2", req_pend[0], 1'b1);
        step(1);
        check("R2", req_pend[0], 1'b0);

        // R5: grant without pending is ignored
        cur_req = "R5";
        grant[0] = 1'b1;
        step(1);
        grant[0] = 1'b0;
        check("R5", acc_out[0], 1'b0);
        step(1);
        check("R5", acc_out[0], 1'b0);

        // R4: sticky edge on channel 1
        cur_req = "R4";
        xreq_n[1] = 1'b0;
        step(3);
        check("R4", req_pend[1], 1'b1);
        xreq_n[1] = 1'b1;
        step(6);
        check("R4", req_pend[1], 1'b1);
        grant[1] = 1'b1;
        step(1);
        grant[1] = 1'b0;
        check("R4", req_pend[1], 1'b0);
        check("R5", acc_out[1], 1'b1);
        step(3);
        check("R4", req_pend[1], 1'b0);
        // edge arriving at the grant edge keeps it pending
        xreq_n[1] = 1'b0;
        step(2);
        xreq_n[1] = 1'b1;
        step(1);
        check("R4", req_pend[1], 1'b1);
        xreq_n[1] = 1'b0;
        step(2);
        grant[1] = 1'b1;
        step(1);
        grant[1] = 1'b0;
        check("R4", req_pend[1], 1'b1);
        xreq_n[1] = 1'b1;
        step(3);

        // R6: accept polarity
        cur_req = "R6";
        cfg_acc_low[1] = 1'b1;
        #1;
        check("R6", acc_out[1], 1'b1);
        grant[1] = 1'b1;
        step(1);
        grant[1] = 1'b0;
        check("R6", acc_out[1], 1'b0);
        step(1);
        check("R6", acc_out[1], 1'b1);
        step(2);
        cfg_acc_low[1] = 1'b0;
        step(1);

        // R7: dual address phase steering
        cur_req = "R7";
        cyc_rd[0] = 1'b1; #1;
        check("R7", ack_out[0], 1'b1);
        step(1);
        cyc_rd[0] = 1'b0; cyc_wr[0] = 1'b1; #1;
        check("R7", ack_out[0], 1'b0);
        step(1);
        cfg_ack_on_wr[0] = 1'b1; #1;
        check("R7", ack_out[0], 1'b1);
        step(1);
        cyc_wr[0] = 1'b0; cyc_rd[0] = 1'b1; #1;
        check("R7", ack_out[0], 1'b0);
        step(1);

        // R8: single address ignores phase select
        cur_req = "R8";
        single_addr[0] = 1'b1; #1;
        check("R8", ack_out[0], 1'b1);
        step(1);
        cfg_ack_on_wr[0] = 1'b0; cyc_rd[0] = 1'b0; cyc_wr[0] = 1'b1; #1;
        check("R8", ack_out[0], 1'b1);
        step(1);

        // R9: acknowledge polarity
        cur_req = "R9";
        cfg_ack_low[0] = 1'b1; #1;
        check("R9", ack_out[0], 1'b0);
        step(1);
        cyc_wr[0] = 1'b0; #1;
        check("R9", ack_out[0], 1'b1);
        step(1);
        cfg_ack_low[0] = 1'b0; single_addr[0] = 1'b0;
        step(1);

        // R10: channel 2 ignores all configuration bits
        cur_req = "R10";
        cfg_edge_det[2] = 1'b1; cfg_acc_low[2] = 1'b1;
        cfg_ack_on_wr[2] = 1'b1; cfg_ack_low[2] = 1'b1;
        #1;
        check("R10", acc_out[2], 1'b0);
        check("R10", ack_out[2], 1'b0);
        cyc_rd[2] = 1'b1; #1;
        check("R10", ack_out[2], 1'b1);
        step(1);
        cyc_rd[2] = 1'b0;
        xreq_n[2] = 1'b0;
        step(3);
        check("R10", req_pend[2], 1'b1);
        xreq_n[2] = 1'b1;
        step(3);
        check("R10", req_pend[2], 1'b0);
        step(2);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule